// File: doc/BRIEF.md
# Camera Pulse Output Gating and Standby Control

This block sits between a camera timing generator's pulse sources and its output pins. It does not create any pulse. A three-bit processing-mode selection picks one of four legal mappings: analog colour, digital colour with fixed separation pulses, digital colour with live separation pulses, or analog monochrome. Each mapping decides, per output, whether the pulse passes, is parked at a fixed level, or is replaced by another pulse. In monochrome, the switching sample-hold pair carries the precharge and data sample pulses. Any other mode combination raises an error flag, and the outputs then follow the analog colour mapping.

In the two digital modes, the second and third clamp pins stop being outputs. Their pin levels are read back as standby controls. A low level on the second clamp pin requests standby; a high level there keeps normal operation whatever the third pin does. In standby, the sensor, readout, discharge, horizontal, reset-gate, sample-hold, delay-line and fast clock outputs are forced low. The master clock, the two outer clamp pulses, blanking, line identification, write enable and burst gate freeze at the value they had in the last cycle before standby. The third clamp pin chooses whether the half-rate clock keeps running during standby.

Top module: `cam_gate_top`

## Requirements
- R1: Mode inputs {proc_digital_i, mono_i, alt_variant_i} are legal only as 000 (analog colour), 100 (digital colour 1), 101 (digital colour 2) or 010 (analog mono). Any other value drives mode_err_o high, and all outputs then follow the analog colour mapping. mode_err_o is low for legal values.
- R2: In analog colour every pulse passes unchanged, and all four clamp pins are driven outputs (clamp_oe_o = 4'b1111).
- R3: In digital colour 1, csep_o is 2'b11, swsh_o is 2'b00 and dly_o is 2'b01 (bit 0 high, bit 1 low). All other pulses pass.
- R4: In digital colour 2, csep_o and swsh_o pass and dly_o is 2'b01.
- R5: In analog mono, csep_o is 2'b11, dly_o is 2'b01, burst_o and lineid_o are 0, swsh_o[0] carries shp_i and swsh_o[1] carries shd_i.
- R6: In both digital modes, clamp_oe_o is 4'b1001 and clamp_o[1], clamp_o[2] are 0. clamp_in_i[0] is the second clamp pin level and clamp_in_i[1] is the third.
- R7: Standby is active only in a legal digital mode with clamp_in_i[0] low. With clamp_in_i[0] high, outputs follow the mode mapping for either level of clamp_in_i[1].
- R8: In standby, vclk_o, rdout_o, disch_o, hclk_o, rgate_o, shp_o, shd_o, csep_o, swsh_o, dly_o and fclk_o are 0 in the same cycle.
- R9: In standby, mck_o, clamp_o[0], clamp_o[3], pblk_o, lineid_o, wen_o and burst_o show their mapped values from the last clock edge before standby began. They follow live values again in the first cycle after standby ends.
- R10: In standby, cl_o follows cl_i when clamp_in_i[1] is 1 and is 0 when it is 0.
- R11: Synchronous reset clears the held values, so standby during or right after reset shows 0 on the freeze group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_digital_i | input | 1 | Digital signal processing select |
| mono_i | input | 1 | Monochrome select |
| alt_variant_i | input | 1 | Digital variant select |
| clamp_in_i | input | 2 | Levels read on the second and third clamp pins |
| vclk_i | input | 4 | Vertical register clocks |
| rdout_i | input | 2 | Charge readout pulses |
| disch_i | input | 1 | Discharge pulse |
| hclk_i | input | 2 | Horizontal register clocks |
| rgate_i | input | 1 | Reset gate pulse |
| shp_i | input | 1 | Precharge sample pulse |
| shd_i | input | 1 | Data sample pulse |
| csep_i | input | 2 | Colour separation sample pulses |
| swsh_i | input | 2 | Switching sample pulses |
| dly_i | input | 2 | Delay line clocks |
| fclk_i | input | 1 | Full-rate clock |
| cl_i | input | 1 | Half-rate clock |
| mck_i | input | 1 | Master clock |
| clamp_i | input | 4 | Clamp pulses |
| pblk_i | input | 1 | Blanking pulse |
| lineid_i | input | 1 | Line identification |
| wen_i | input | 1 | Write enable |
| burst_i | input | 1 | Burst gate pulse |
| vclk_o | output | 4 | Gated vertical clocks |
| rdout_o | output | 2 | Gated readout pulses |
| disch_o | output | 1 | Gated discharge pulse |
| hclk_o | output | 2 | Gated horizontal clocks |
| rgate_o | output | 1 | Gated reset gate |
| shp_o | output | 1 | Gated precharge sample |
| shd_o | output | 1 | Gated data sample |
| csep_o | output | 2 | Mapped separation pulses |
| swsh_o | output | 2 | Mapped switching pulses |
| dly_o | output | 2 | Mapped delay clocks |
| fclk_o | output | 1 | Gated full-rate clock |
| cl_o | output | 1 | Gated half-rate clock |
| mck_o | output | 1 | Master clock, frozen in standby |
| clamp_o | output | 4 | Clamp pulse pin values |
| clamp_oe_o | output | 4 | Clamp pin drive enables |
| pblk_o | output | 1 | Blanking, frozen in standby |
| lineid_o | output | 1 | Line identification, frozen in standby |
| wen_o | output | 1 | Write enable, frozen in standby |
| burst_o | output | 1 | Burst gate, frozen in standby |
| mode_err_o | output | 1 | Illegal mode flag |

## Verification
The mapping is tried with fresh random pulse values on every input in every cycle, under each of the eight mode-bit combinations. A parked or substituted output therefore stands apart from a passed one, and an illegal code stands apart from analog colour. Standby is entered with the freeze group at known ones, then the pulses toggle. This separates freezing from passing and from forcing low. It also shows whether release happens in the right cycle. Both third-pin levels are tried in standby and in normal operation, which separates the two standby flavours and confirms that the second pin alone gates standby. A long random run changes modes and clamp levels freely against the reference model.

// File: rtl/cam_gate_pkg.sv
package cam_gate_pkg;

    localparam int VCLK_W  = 4;
    localparam int READ_W  = 2;
    localparam int HCLK_W  = 2;
    localparam int PAIR_W  = 2;
    localparam int CLAMP_W = 4;

    localparam logic [PAIR_W-1:0]  PAIR_HIGH = '1;
    localparam logic [PAIR_W-1:0]  DLY_PARK  = {{(PAIR_W-1){1'b0}}, 1'b1};
    localparam logic [CLAMP_W-1:0] OE_ALL    = '1;
    localparam logic [CLAMP_W-1:0] OE_DIG    = {1'b1, {(CLAMP_W-2){1'b0}}, 1'b1};

    typedef enum logic [1:0] {
        MODE_ACOL  = 2'd0,
        MODE_DCOL1 = 2'd1,
        MODE_DCOL2 = 2'd2,
        MODE_AMONO = 2'd3
    } cam_mode_e;

    typedef struct packed {
        cam_mode_e mode;
        logic      bad;
    } mode_t;

    // Outputs forced low in standby
    typedef struct packed {
        logic [VCLK_W-1:0] vclk;
        logic [READ_W-1:0] rdout;
        logic              disch;
        logic [HCLK_W-1:0] hclk;
        logic              rgate;
        logic              shp;
        logic              shd;
        logic [PAIR_W-1:0] csep;
        logic [PAIR_W-1:0] swsh;
        logic [PAIR_W-1:0] dly;
        logic              fclk;
        logic              cl;
    } fast_t;

    // Outputs frozen in standby
    typedef struct packed {
        logic mck;
        logic clamp_a;
        logic clamp_d;
        logic pblk;
        logic lineid;
        logic wen;
        logic burst;
    } slow_t;

    function automatic mode_t decode_mode(input logic dig, input logic mono, input logic alt);
        mode_t r;
        r.bad = 1'b0;
        case ({dig, mono, alt})
            3'b000:  r.mode = MODE_ACOL;
            3'b100:  r.mode = MODE_DCOL1;
            3'b101:  r.mode = MODE_DCOL2;
            3'b010:  r.mode = MODE_AMONO;
            default: begin
                r.mode = MODE_ACOL;
                r.bad  = 1'b1;
            end
        endcase
        return r;
    endfunction

    function automatic logic is_digital(input cam_mode_e m);
        return (m == MODE_DCOL1) || (m == MODE_DCOL2);
    endfunction

endpackage

// File: rtl/cam_mode_dec.sv
module cam_mode_dec
    import cam_gate_pkg::*;
(
    input  logic      dig_i,
    input  logic      mono_i,
    input  logic      alt_i,
    output cam_mode_e mode_o,
    output logic      bad_o,
    output logic      digital_o
);
    mode_t dec;

    always_comb begin
        dec       = decode_mode(dig_i, mono_i, alt_i);
        mode_o    = dec.mode;
        bad_o     = dec.bad;
        digital_o = is_digital(dec.mode);
    end
endmodule

// File: rtl/cam_mode_gate.sv
module cam_mode_gate
    import cam_gate_pkg::*;
(
    input  cam_mode_e          mode_i,
    input  fast_t              fast_i,
    input  slow_t              slow_i,
    input  logic [CLAMP_W-1:0] clamp_i,
    output fast_t              fast_o,
    output slow_t              slow_o,
    output logic [CLAMP_W-1:0] clamp_mid_o,
    output logic [CLAMP_W-1:0] clamp_oe_o
);
    always_comb begin
        fast_o = fast_i;
        slow_o = slow_i;
        case (mode_i)
            MODE_DCOL1: begin
                fast_o.csep = PAIR_HIGH;
                fast_o.swsh = '0;
                fast_o.dly  = DLY_PARK;
            end
            MODE_DCOL2: begin
                fast_o.dly  = DLY_PARK;
            end
            MODE_AMONO: begin
                fast_o.csep   = PAIR_HIGH;
                fast_o.dly    = DLY_PARK;
                fast_o.swsh   = {fast_i.shd, fast_i.shp};
                slow_o.burst  = 1'b0;
                slow_o.lineid = 1'b0;
            end
            default: ;
        endcase
    end

    // Inner clamp pins turn into inputs in digital modes
    for (genvar g = 0; g < CLAMP_W; g++) begin : g_clamp
        if (g == 0 || g == CLAMP_W-1) begin : g_outer
            assign clamp_oe_o[g]  = 1'b1;
            assign clamp_mid_o[g] = clamp_i[g];
        end else begin : g_inner
            assign clamp_oe_o[g]  = !is_digital(mode_i);
            assign clamp_mid_o[g] = is_digital(mode_i) ? 1'b0 : clamp_i[g];
        end
    end
endmodule

// File: rtl/cam_stby_ctrl.sv
module cam_stby_ctrl
    import cam_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       digital_i,
    input  logic [1:0] clamp_in_i,
    input  fast_t      fast_i,
    input  slow_t      slow_i,
    output fast_t      fast_o,
    output slow_t      slow_o
);
    logic  standby;
    logic  keep_cl;
    slow_t hold_q;

    assign standby = digital_i && !clamp_in_i[0];
    assign keep_cl = clamp_in_i[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (!standby) begin
            hold_q <= slow_i;
        end
    end

    always_comb begin
        if (standby) begin
            fast_o    = '0;
            fast_o.cl = keep_cl ? fast_i.cl : 1'b0;
            slow_o    = hold_q;
        end else begin
            fast_o = fast_i;
            slow_o = slow_i;
        end
    end
endmodule

// File: rtl/cam_gate_top.sv
module cam_gate_top
    import cam_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               proc_digital_i,
    input  logic               mono_i,
    input  logic               alt_variant_i,
    input  logic [1:0]         clamp_in_i,
    input  logic [VCLK_W-1:0]  vclk_i,
    input  logic [READ_W-1:0]  rdout_i,
    input  logic               disch_i,
    input  logic [HCLK_W-1:0]  hclk_i,
    input  logic               rgate_i,
    input  logic               shp_i,
    input  logic               shd_i,
    input  logic [PAIR_W-1:0]  csep_i,
    input  logic [PAIR_W-1:0]  swsh_i,
    input  logic [PAIR_W-1:0]  dly_i,
    input  logic               fclk_i,
    input  logic               cl_i,
    input  logic               mck_i,
    input  logic [CLAMP_W-1:0] clamp_i,
    input  logic               pblk_i,
    input  logic               lineid_i,
    input  logic               wen_i,
    input  logic               burst_i,
    output logic [VCLK_W-1:0]  vclk_o,
    output logic [READ_W-1:0]  rdout_o,
    output logic               disch_o,
    output logic [HCLK_W-1:0]  hclk_o,
    output logic               rgate_o,
    output logic               shp_o,
    output logic               shd_o,
    output logic [PAIR_W-1:0]  csep_o,
    output logic [PAIR_W-1:0]  swsh_o,
    output logic [PAIR_W-1:0]  dly_o,
    output logic               fclk_o,
    output logic               cl_o,
    output logic               mck_o,
    output logic [CLAMP_W-1:0] clamp_o,
    output logic [CLAMP_W-1:0] clamp_oe_o,
    output logic               pblk_o,
    output logic               lineid_o,
    output logic               wen_o,
    output logic               burst_o,
    output logic               mode_err_o
);
    cam_mode_e          mode;
    logic               digital;
    fast_t              fast_raw, fast_map, fast_out;
    slow_t              slow_raw, slow_map, slow_out;
    logic [CLAMP_W-1:0] clamp_mid;

    assign fast_raw = '{vclk: vclk_i, rdout: rdout_i, disch: disch_i, hclk: hclk_i,
                        rgate: rgate_i, shp: shp_i, shd: shd_i, csep: csep_i,
                        swsh: swsh_i, dly: dly_i, fclk: fclk_i, cl: cl_i};
    assign slow_raw = '{mck: mck_i, clamp_a: clamp_i[0], clamp_d: clamp_i[CLAMP_W-1],
                        pblk: pblk_i, lineid: lineid_i, wen: wen_i, burst: burst_i};

    cam_mode_dec u_dec (
        .dig_i     (proc_digital_i),
        .mono_i    (mono_i),
        .alt_i     (alt_variant_i),
        .mode_o    (mode),
        .bad_o     (mode_err_o),
        .digital_o (digital)
    );

    cam_mode_gate u_map (
        .mode_i      (mode),
        .fast_i      (fast_raw),
        .slow_i      (slow_raw),
        .clamp_i     (clamp_i),
        .fast_o      (fast_map),
        .slow_o      (slow_map),
        .clamp_mid_o (clamp_mid),
        .clamp_oe_o  (clamp_oe_o)
    );

    cam_stby_ctrl u_stby (
        .clk        (clk),
        .rst        (rst),
        .digital_i  (digital),
        .clamp_in_i (clamp_in_i),
        .fast_i     (fast_map),
        .slow_i     (slow_map),
        .fast_o     (fast_out),
        .slow_o     (slow_out)
    );

    assign vclk_o   = fast_out.vclk;
    assign rdout_o  = fast_out.rdout;
    assign disch_o  = fast_out.disch;
    assign hclk_o   = fast_out.hclk;
    assign rgate_o  = fast_out.rgate;
    assign shp_o    = fast_out.shp;
    assign shd_o    = fast_out.shd;
    assign csep_o   = fast_out.csep;
    assign swsh_o   = fast_out.swsh;
    assign dly_o    = fast_out.dly;
    assign fclk_o   = fast_out.fclk;
    assign cl_o     = fast_out.cl;
    assign mck_o    = slow_out.mck;
    assign pblk_o   = slow_out.pblk;
    assign lineid_o = slow_out.lineid;
    assign wen_o    = slow_out.wen;
    assign burst_o  = slow_out.burst;
    assign clamp_o  = {slow_out.clamp_d, clamp_mid[CLAMP_W-2:1], slow_out.clamp_a};
endmodule

// File: rtl/cam_gate_chk.sv
module cam_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       proc_digital_i,
    input logic       mono_i,
    input logic       alt_variant_i,
    input logic [1:0] clamp_in_i,
    input logic       shp_i,
    input logic       shd_i,
    input logic       cl_i,
    input logic [3:0] vclk_o,
    input logic [1:0] hclk_o,
    input logic       fclk_o,
    input logic [1:0] csep_o,
    input logic [1:0] swsh_o,
    input logic [1:0] dly_o,
    input logic       cl_o,
    input logic       mck_o,
    input logic       pblk_o,
    input logic       wen_o,
    input logic       burst_o,
    input logic [3:0] clamp_oe_o,
    input logic       mode_err_o
);
    logic [2:0] sel;
    logic       legal, dcol1, mono, digi, stb;

    assign sel   = {proc_digital_i, mono_i, alt_variant_i};
    assign legal = (sel == 3'b000) || (sel == 3'b100) || (sel == 3'b101) || (sel == 3'b010);
    assign dcol1 = (sel == 3'b100);
    assign mono  = (sel == 3'b010);
    assign digi  = (sel == 3'b100) || (sel == 3'b101);
    assign stb   = digi && !clamp_in_i[0];

    p_err_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_err_o == !legal));

    p_err_map_r1: assert property (@(posedge clk) disable iff (rst)
        mode_err_o |-> (clamp_oe_o == 4'b1111));

    p_dcol1_park_r3: assert property (@(posedge clk) disable iff (rst)
        (dcol1 && clamp_in_i[0]) |-> (csep_o == 2'b11 && swsh_o == 2'b00 && dly_o == 2'b01));

    p_mono_swap_r5: assert property (@(posedge clk) disable iff (rst)
        mono |-> (swsh_o == {shd_i, shp_i} && burst_o == 1'b0 && csep_o == 2'b11));

    p_dir_r6: assert property (@(posedge clk) disable iff (rst)
        digi |-> (clamp_oe_o == 4'b1001));

    p_force_low_r8: assert property (@(posedge clk) disable iff (rst)
        stb |-> (vclk_o == '0 && hclk_o == '0 && fclk_o == 1'b0 && dly_o == '0));

    p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (stb && $past(stb)) |-> ($stable(mck_o) && $stable(pblk_o) && $stable(wen_o)));

    p_cl_flavour_r10: assert property (@(posedge clk) disable iff (rst)
        stb |-> (cl_o == (clamp_in_i[1] & cl_i)));
endmodule

bind cam_gate_top cam_gate_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .proc_digital_i (proc_digital_i),
    .mono_i         (mono_i),
    .alt_variant_i  (alt_variant_i),
    .clamp_in_i     (clamp_in_i),
    .shp_i          (shp_i),
    .shd_i          (shd_i),
    .cl_i           (cl_i),
    .vclk_o         (vclk_o),
    .hclk_o         (hclk_o),
    .fclk_o         (fclk_o),
    .csep_o         (csep_o),
    .swsh_o         (swsh_o),
    .dly_o          (dly_o),
    .cl_o           (cl_o),
    .mck_o          (mck_o),
    .pblk_o         (pblk_o),
    .wen_o          (wen_o),
    .burst_o        (burst_o),
    .clamp_oe_o     (clamp_oe_o),
    .mode_err_o     (mode_err_o)
);

// File: tb/cam_gate_top_tb_top.sv
module cam_gate_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       gm, d2, t2;
    logic [1:0] clin;
    logic [3:0] vclk_i;  logic [1:0] rdout_i; logic disch_i; logic [1:0] hclk_i;
    logic       rgate_i, shp_i, shd_i;
    logic [1:0] csep_i, swsh_i, dly_i;
    logic       fclk_i, cl_i, mck_i;
    logic [3:0] clamp_i;
    logic       pblk_i, lineid_i, wen_i, burst_i;

    logic [3:0] vclk_o;  logic [1:0] rdout_o; logic disch_o; logic [1:0] hclk_o;
    logic       rgate_o, shp_o, shd_o;
    logic [1:0] csep_o, swsh_o, dly_o;
    logic       fclk_o, cl_o, mck_o;
    logic [3:0] clamp_o, clamp_oe_o;
    logic       pblk_o, lineid_o, wen_o, burst_o, mode_err_o;

    int checks = 0;
    int errors = 0;
    logic [6:0] hold_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_gate_top dut_i (
        .clk(clk), .rst(rst), .proc_digital_i(gm), .mono_i(d2), .alt_variant_i(t2),
        .clamp_in_i(clin), .vclk_i(vclk_i), .rdout_i(rdout_i), .disch_i(disch_i),
        .hclk_i(hclk_i), .rgate_i(rgate_i), .shp_i(shp_i), .shd_i(shd_i),
        .csep_i(csep_i), .swsh_i(swsh_i), .dly_i(dly_i), .fclk_i(fclk_i), .cl_i(cl_i),
        .mck_i(mck_i), .clamp_i(clamp_i), .pblk_i(pblk_i), .lineid_i(lineid_i),
        .wen_i(wen_i), .burst_i(burst_i),
        .vclk_o(vclk_o), .rdout_o(rdout_o), .disch_o(disch_o), .hclk_o(hclk_o),
        .rgate_o(rgate_o), .shp_o(shp_o), .shd_o(shd_o), .csep_o(csep_o),
        .swsh_o(swsh_o), .dly_o(dly_o), .fclk_o(fclk_o), .cl_o(cl_o), .mck_o(mck_o),
        .clamp_o(clamp_o), .clamp_oe_o(clamp_oe_o), .pblk_o(pblk_o),
        .lineid_o(lineid_o), .wen_o(wen_o), .burst_o(burst_o), .mode_err_o(mode_err_o)
    );

    task automatic chk(input string tag, input string name, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
        end
    endtask

    task automatic rand_pulses();
        {vclk_i, rdout_i, disch_i, hclk_i, rgate_i, shp_i, shd_i} = 13'($urandom);
        {csep_i, swsh_i, dly_i, fclk_i, cl_i, mck_i} = 9'($urandom);
        {clamp_i, pblk_i, lineid_i, wen_i, burst_i} = 8'($urandom);
    endtask

    // Compare at mid-cycle, then advance the model across the next edge
    task automatic cycle();
        logic       legal, digi, sb;
        int         m;
        string      mt, ft, st;
        logic [1:0] e_csep, e_swsh, e_dly;
        logic       e_burst, e_id;
        logic [6:0] live, e_slow, nxt;
        #1;
        legal = ({gm, d2, t2} == 3'b000) || ({gm, d2, t2} == 3'b100) ||
                ({gm, d2, t2} == 3'b101) || ({gm, d2, t2} == 3'b010);
        if (!legal)                   m = 0;
        else if ({gm, d2, t2} == 3'b100) m = 1;
        else if ({gm, d2, t2} == 3'b101) m = 2;
        else if ({gm, d2, t2} == 3'b010) m = 3;
        else                          m = 0;
        mt = !legal ? "R1" : (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
        e_csep = csep_i; e_swsh = swsh_i; e_dly = dly_i; e_burst = burst_i; e_id = lineid_i;
        if (m == 1) begin e_csep = 2'b11; e_swsh = 2'b00; e_dly = 2'b01; end
        if (m == 2) begin e_dly = 2'b01; end
        if (m == 3) begin
            e_csep = 2'b11; e_dly = 2'b01; e_burst = 1'b0; e_id = 1'b0; e_swsh = {shd_i, shp_i};
        end
        digi = (m == 1) || (m == 2);
        sb   = digi && !clin[0];
        ft   = sb ? "R8" : (digi && !clin[1]) ? "R7" : mt;
        st   = sb ? (rst ? "R11" : "R9") : mt;
        live = {mck_i, clamp_i[0], clamp_i[3], pblk_i, e_id, wen_i, e_burst};
        e_slow = sb ? hold_m : live;

        chk("R1", "mode_err", 32'(mode_err_o), 32'(!legal));
        chk("R6", "clamp_oe", 32'(clamp_oe_o), digi ? 32'h9 : 32'hF);
        chk(ft, "vclk",  32'(vclk_o),  sb ? 0 : 32'(vclk_i));
        chk(ft, "rdout", 32'(rdout_o), sb ? 0 : 32'(rdout_i));
        chk(ft, "misc",  32'({disch_o, hclk_o, rgate_o, shp_o, shd_o, fclk_o}),
            sb ? 0 : 32'({disch_i, hclk_i, rgate_i, shp_i, shd_i, fclk_i}));
        chk(ft, "csep",  32'(csep_o), sb ? 0 : 32'(e_csep));
        chk(ft, "swsh",  32'(swsh_o), sb ? 0 : 32'(e_swsh));
        chk(ft, "dly",   32'(dly_o),  sb ? 0 : 32'(e_dly));
        chk(sb ? "R10" : ft, "cl", 32'(cl_o), sb ? 32'(clin[1] & cl_i) : 32'(cl_i));
        chk(st, "freeze_grp",
            32'({mck_o, clamp_o[0], clamp_o[3], pblk_o, lineid_o, wen_o, burst_o}), 32'(e_slow));
        chk("R6", "clamp_inner", 32'(clamp_o[2:1]), digi ? 0 : 32'(clamp_i[2:1]));

        nxt = rst ? 7'd0 : (sb ? hold_m : live);
        @(posedge clk);
        hold_m = nxt;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        {gm, d2, t2} = 3'b100;
        clin = 2'b00;
        rand_pulses();
        @(negedge clk);
        // R11: standby held through reset shows cleared freeze group
        for (int i = 0; i < 4; i++) begin rand_pulses(); cycle(); end
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin rand_pulses(); cycle(); end

        // R1..R6: every mode-bit combination, clamp pin 2 high
        for (int s = 0; s < 8; s++) begin
            {gm, d2, t2} = 3'(s);
            for (int k = 0; k < 4; k++) begin
                clin = {k[0], 1'b1};
                rand_pulses();
                cycle();
            end
        end

        // R9, R10: enter standby with freeze group at ones, then toggle inputs
        {gm, d2, t2} = 3'b101;
        clin = 2'b11;
        rand_pulses();
        {mck_i, clamp_i, pblk_i, lineid_i, wen_i, burst_i} = '1;
        cycle();
        for (int i = 0; i < 6; i++) begin
            clin = {i[0], 1'b0};
            rand_pulses();
            cycle();
        end
        clin = 2'b01;
        rand_pulses();
        cycle();

        // Mixed random run
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) {gm, d2, t2} = 3'($urandom);
            if ($urandom_range(0, 3) == 0) clin = 2'($urandom);
            rand_pulses();
            cycle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule